// File: doc/BRIEF.md
# Multi-core halt power sequencer

This block sits beside a group of processor cores and decides when the whole package may drop into a deeper halt. It watches one halt flag per core. While any core is still running, the package stays in normal operation. Once every core reports halt, there are two outcomes. If the deep-halt enable is clear, the package only enters a plain halt. If the enable is set, the block lowers the operating point before settling into the deep halt.

Lowering always goes in the same order: the core clock ratio comes down first, and the voltage identifier (VID) follows. Leaving the deep halt goes the other way. The VID is raised first, while the ratio is still low, and the ratio follows. Each step is handed to an external actuator as a held request and finishes when that actuator acknowledges.

The restored values are the run values captured when the package entered the deep halt. A stop-clock request that arrives while halted parks the block in a stop state. When the request is released, the block goes back to the halt it came from. Snoop requests are acknowledged in every state, and the bus clock is never touched.

Top module: `halt_pwr_seq`

## Requirements
- R1: After reset the block reports run (`pkg_state` = 0), both busy flags and `seq_err` are low, and `ratio_req`/`vid_req` equal `run_ratio`/`run_vid`.
- R2: While at least one `core_halt` bit is low, the block stays in run (`pkg_state` = 0) with both busy flags low, whatever `xhalt_en` is.
- R3: With all cores halted and `xhalt_en` low, the block enters plain halt (`pkg_state` = 1) with no busy flag and the requests still equal to the run inputs.
- R4: With all cores halted and `xhalt_en` high, the block reports entry (`pkg_state` = 4) and goes through these steps. First it raises `ratio_busy` with `ratio_req` = LOW_RATIO and `vid_req` unchanged. After `ratio_ack` it raises `vid_busy` with `vid_req` = LOW_VID. After `vid_ack` it reports deep halt (`pkg_state` = 2).
- R5: A wake event (`wake_evt` high or any core un-halted) in deep halt starts the exit (`pkg_state` = 5). The block first raises `vid_busy` with the VID restored while `ratio_req` stays LOW_RATIO. After `vid_ack` it raises `ratio_busy` with the ratio restored. After `ratio_ack` it returns to run.
- R6: The restored ratio and VID are the run inputs sampled at entry, even if `run_ratio`/`run_vid` change during the deep halt. Back in run, the requests follow the inputs again.
- R7: A `stop_clk_req` in plain or deep halt moves the block to stop (`pkg_state` = 3) with the requests unchanged. On release it returns to the same halt state, not to run.
- R8: A `stop_clk_req` in run moves the block to stop (`pkg_state` = 3). On release it returns to run.
- R9: `snoop_ack` is high exactly one cycle after each cycle that `snoop_req` is high, in every state.
- R10: If a busy flag stays high for ACK_TMO consecutive cycles without its acknowledge, `seq_err` rises and stays high until reset.
- R11: `ratio_busy` and `vid_busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_halt | input | NCORES | Per-core halt flag |
| xhalt_en | input | 1 | Deep-halt enable |
| wake_evt | input | 1 | Break event that ends a halt |
| stop_clk_req | input | 1 | Stop-clock request, level |
| snoop_req | input | 1 | Bus snoop request |
| snoop_ack | output | 1 | Snoop acknowledge, one cycle later |
| run_ratio | input | RATIO_W | Normal core clock ratio |
| run_vid | input | VID_W | Normal voltage identifier |
| ratio_req | output | RATIO_W | Requested core clock ratio |
| ratio_busy | output | 1 | Ratio change pending |
| ratio_ack | input | 1 | Ratio actuator acknowledge |
| vid_req | output | VID_W | Requested voltage identifier |
| vid_busy | output | 1 | VID change pending |
| vid_ack | input | 1 | VID actuator acknowledge |
| pkg_state | output | 3 | 0 run, 1 halt, 2 deep halt, 3 stop, 4 entering, 5 leaving |
| seq_err | output | 1 | Sticky acknowledge timeout |

## Verification
The bench builds the block with four cores, two synchronizer stages on the halt flags, a 6-bit ratio with LOW_RATIO 6, a 7-bit VID with LOW_VID 20 and ACK_TMO of 16. With four cores there are many partial-halt masks to draw from at random. The synchronizer stages add real latency between a halt flag and the state change. The short timeout lets the error path be reached within a few dozen cycles. The actuator acknowledges after a random delay of zero to three cycles, so each busy phase is exercised at lengths from one cycle up.

// File: rtl/hps_pkg.sv
package hps_pkg;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_HALT     = 3'd1,
      ST_DN_RATIO = 3'd2,
      ST_DN_VID   = 3'd3,
      ST_XHALT    = 3'd4,
      ST_UP_VID   = 3'd5,
      ST_UP_RATIO = 3'd6,
      ST_STOP     = 3'd7
   } seq_st_t;

   localparam logic [2:0] IND_RUN   = 3'd0;
   localparam logic [2:0] IND_HALT  = 3'd1;
   localparam logic [2:0] IND_XHALT = 3'd2;
   localparam logic [2:0] IND_STOP  = 3'd3;
   localparam logic [2:0] IND_ENTER = 3'd4;
   localparam logic [2:0] IND_LEAVE = 3'd5;

   // external state code for each internal sequencer state
   function automatic logic [2:0] ind_of(seq_st_t s);
      logic [2:0] r;
      case (s)
         ST_RUN:                 r = IND_RUN;
         ST_HALT:                r = IND_HALT;
         ST_DN_RATIO, ST_DN_VID: r = IND_ENTER;
         ST_XHALT:               r = IND_XHALT;
         ST_UP_VID, ST_UP_RATIO: r = IND_LEAVE;
         default:                r = IND_STOP;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/hps_halt_detect.sv
module hps_halt_detect #(
   parameter int NCORES = 2,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCORES-1:0] halt_i,
   output logic              all_o
);

   logic [NCORES-1:0] flags;

   generate
      if (STAGES == 0) begin : g_direct
         assign flags = halt_i;
      end else begin : g_sync
         logic [STAGES-1:0][NCORES-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= halt_i;
               for (int k = 1; k < STAGES; k++) begin
                  sh[k] <= sh[k-1];
               end
            end
         end
         assign flags = sh[STAGES-1];
      end
   endgenerate

   assign all_o = &flags;

endmodule

// File: rtl/hps_ack_timer.sv
module hps_ack_timer #(
   parameter int TMO = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_i,
   input  logic ack_i,
   output logic expired_o
);

   localparam int CW = $clog2(TMO + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         expired_o <= 1'b0;
      end else if (wait_i && !ack_i) begin
         if (cnt == CW'(TMO - 1)) begin
            expired_o <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= '0;
      end
   end

   p_cnt_bound_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(TMO - 1));

   p_err_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      expired_o |=> expired_o);

endmodule

// File: rtl/hps_level_hold.sv
module hps_level_hold #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (cap_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/halt_pwr_seq.sv
module halt_pwr_seq
   import hps_pkg::*;
#(
   parameter int NCORES           = 2,
   parameter int HALT_SYNC_STAGES = 2,
   parameter int RATIO_W          = 6,
   parameter int VID_W            = 7,
   parameter int LOW_RATIO        = 6,
   parameter int LOW_VID          = 20,
   parameter int ACK_TMO          = 1024
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NCORES-1:0]  core_halt,
   input  logic               xhalt_en,
   input  logic               wake_evt,
   input  logic               stop_clk_req,
   input  logic               snoop_req,
   output logic               snoop_ack,
   input  logic [RATIO_W-1:0] run_ratio,
   input  logic [VID_W-1:0]   run_vid,
   output logic [RATIO_W-1:0] ratio_req,
   output logic               ratio_busy,
   input  logic               ratio_ack,
   output logic [VID_W-1:0]   vid_req,
   output logic               vid_busy,
   input  logic               vid_ack,
   output logic [2:0]         pkg_state,
   output logic               seq_err
);

   localparam logic [RATIO_W-1:0] LOW_R = RATIO_W'(LOW_RATIO);
   localparam logic [VID_W-1:0]   LOW_V = VID_W'(LOW_VID);

   initial begin
      assert (NCORES >= 1) else $error("NCORES must be at least 1");
      assert (HALT_SYNC_STAGES >= 0 && HALT_SYNC_STAGES <= 3)
         else $error("HALT_SYNC_STAGES out of range 0..3");
      assert (LOW_RATIO >= 0 && LOW_RATIO < (1 << RATIO_W))
         else $error("LOW_RATIO does not fit RATIO_W");
      assert (LOW_VID >= 0 && LOW_VID < (1 << VID_W))
         else $error("LOW_VID does not fit VID_W");
      assert (ACK_TMO >= 2) else $error("ACK_TMO must be at least 2");
   end

   logic               all_h;
   logic               exit_c;
   logic               cap;
   logic [RATIO_W-1:0] saved_ratio;
   logic [VID_W-1:0]   saved_vid;
   seq_st_t            st, st_nx;
   seq_st_t            ret_st, ret_nx;

   hps_halt_detect #(.NCORES(NCORES), .STAGES(HALT_SYNC_STAGES)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .halt_i (core_halt),
      .all_o  (all_h)
   );

   assign exit_c = wake_evt | ~all_h;
   assign cap    = (st == ST_RUN) && !stop_clk_req && all_h && xhalt_en;

   hps_level_hold #(.W(RATIO_W)) u_hold_ratio (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_i (cap),
      .d_i   (run_ratio),
      .q_o   (saved_ratio)
   );

   hps_level_hold #(.W(VID_W)) u_hold_vid (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_i (cap),
      .d_i   (run_vid),
      .q_o   (saved_vid)
   );

   always_comb begin
      st_nx  = st;
      ret_nx = ret_st;
      case (st)
         ST_RUN: begin
            if (stop_clk_req) begin
               st_nx  = ST_STOP;
               ret_nx = ST_RUN;
            end else if (all_h) begin
               st_nx = xhalt_en ? ST_DN_RATIO : ST_HALT;
            end
         end
         ST_HALT: begin
            if (stop_clk_req) begin
               st_nx  = ST_STOP;
               ret_nx = ST_HALT;
            end else if (exit_c) begin
               st_nx = ST_RUN;
            end
         end
         ST_DN_RATIO: if (ratio_ack) st_nx = ST_DN_VID;
         ST_DN_VID:   if (vid_ack)   st_nx = ST_XHALT;
         ST_XHALT: begin
            if (stop_clk_req) begin
               st_nx  = ST_STOP;
               ret_nx = ST_XHALT;
            end else if (exit_c) begin
               st_nx = ST_UP_VID;
            end
         end
         ST_UP_VID:   if (vid_ack)   st_nx = ST_UP_RATIO;
         ST_UP_RATIO: if (ratio_ack) st_nx = ST_RUN;
         default:     if (!stop_clk_req) st_nx = ret_st;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         ret_st    <= ST_RUN;
         snoop_ack <= 1'b0;
      end else begin
         st        <= st_nx;
         ret_st    <= ret_nx;
         snoop_ack <= snoop_req;
      end
   end

   always_comb begin
      ratio_req = run_ratio;
      vid_req   = run_vid;
      case (st)
         ST_DN_RATIO: ratio_req = LOW_R;
         ST_DN_VID, ST_XHALT: begin
            ratio_req = LOW_R;
            vid_req   = LOW_V;
         end
         ST_UP_VID: begin
            ratio_req = LOW_R;
            vid_req   = saved_vid;
         end
         ST_UP_RATIO: begin
            ratio_req = saved_ratio;
            vid_req   = saved_vid;
         end
         ST_STOP: begin
            if (ret_st == ST_XHALT) begin
               ratio_req = LOW_R;
               vid_req   = LOW_V;
            end
         end
         default: ;
      endcase
   end

   assign ratio_busy = (st == ST_DN_RATIO) || (st == ST_UP_RATIO);
   assign vid_busy   = (st == ST_DN_VID)   || (st == ST_UP_VID);
   assign pkg_state  = ind_of(st);

   hps_ack_timer #(.TMO(ACK_TMO)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .wait_i    (ratio_busy | vid_busy),
      .ack_i     ((ratio_busy & ratio_ack) | (vid_busy & vid_ack)),
      .expired_o (seq_err)
   );

   p_partial_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (pkg_state == IND_RUN && !all_h) |=>
         (pkg_state != IND_HALT && pkg_state != IND_ENTER));

   p_plain_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pkg_state) == IND_RUN && pkg_state == IND_HALT) |-> !$past(xhalt_en));

   p_dn_order_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(vid_busy) && pkg_state == IND_ENTER) |-> $past(ratio_busy));

   p_up_order_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ratio_busy) && pkg_state == IND_LEAVE) |-> $past(vid_busy));

   p_stop_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pkg_state == IND_STOP && $past(pkg_state) == IND_XHALT) |->
         ($stable(ratio_req) && $stable(vid_req)));

   p_stop_ret_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP && ret_st != ST_RUN && !stop_clk_req) |=> pkg_state != IND_RUN);

   p_stop_run_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP && ret_st == ST_RUN && !stop_clk_req) |=> pkg_state == IND_RUN);

   p_snoop_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      snoop_req |=> snoop_ack);

   p_one_busy_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !(ratio_busy && vid_busy));

endmodule

// File: tb/halt_pwr_seq_tb.sv
module halt_pwr_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int RW         = 6;
   localparam int VW         = 7;
   localparam int LOW_R      = 6;
   localparam int LOW_V      = 20;
   localparam int TMO        = 16;
   localparam int WD_CYCLES  = 50000;

   localparam logic [2:0] S_RUN   = 3'd0;
   localparam logic [2:0] S_HALT  = 3'd1;
   localparam logic [2:0] S_XHALT = 3'd2;
   localparam logic [2:0] S_STOP  = 3'd3;
   localparam logic [2:0] S_ENTER = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  core_halt;
   logic          xhalt_en, wake_evt, stop_clk_req, snoop_req, snoop_ack;
   logic [RW-1:0] run_ratio, ratio_req;
   logic [VW-1:0] run_vid, vid_req;
   logic          ratio_busy, ratio_ack, vid_busy, vid_ack;
   logic [2:0]    pkg_state;
   logic          seq_err;

   int  checks = 0;
   int  fails  = 0;
   int  bad11  = 0;
   bit  auto_ack = 1'b1;
   int  ack_dly = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   halt_pwr_seq #(
      .NCORES(N), .HALT_SYNC_STAGES(2), .RATIO_W(RW), .VID_W(VW),
      .LOW_RATIO(LOW_R), .LOW_VID(LOW_V), .ACK_TMO(TMO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .xhalt_en(xhalt_en),
      .wake_evt(wake_evt), .stop_clk_req(stop_clk_req), .snoop_req(snoop_req),
      .snoop_ack(snoop_ack), .run_ratio(run_ratio), .run_vid(run_vid),
      .ratio_req(ratio_req), .ratio_busy(ratio_busy), .ratio_ack(ratio_ack),
      .vid_req(vid_req), .vid_busy(vid_busy), .vid_ack(vid_ack),
      .pkg_state(pkg_state), .seq_err(seq_err)
   );

   // actuator model: acknowledges a pending change after 0..3 cycles
   always @(negedge clk) begin
      ratio_ack = 1'b0;
      vid_ack   = 1'b0;
      if (rst_n && auto_ack && (ratio_busy || vid_busy)) begin
         if (ack_dly == 0) begin
            ratio_ack = ratio_busy;
            vid_ack   = vid_busy;
            ack_dly   = int'($urandom_range(0, 3));
         end else begin
            ack_dly--;
         end
      end
      if (rst_n && ratio_busy && vid_busy) bad11++;
   end

   function automatic logic [N-1:0] all_mask();
      return {N{1'b1}};
   endfunction

   function automatic bit expect_run(logic [N-1:0] m);
      return !(&m);
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", fails, checks);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wait_ind(input logic [2:0] code, input int lim, output bit hit);
      hit = 1'b0;
      for (int i = 0; i < lim; i++) begin
         tick();
         if (pkg_state == code) begin
            hit = 1'b1;
            break;
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic snoop_chk(input string tag);
      snoop_req = 1'b1;
      tick();
      snoop_req = 1'b0;
      chk(snoop_ack == 1'b1, tag, int'(snoop_ack), 1);
      tick();
      chk(snoop_ack == 1'b0, tag, int'(snoop_ack), 0);
   endtask

   task automatic enter_ext(input logic [RW-1:0] o_r, input logic [VW-1:0] o_v);
      int ph = 0;
      bit order_ok = 1'b1;
      bit vals_ok  = 1'b1;
      xhalt_en  = 1'b1;
      core_halt = all_mask();
      for (int i = 0; i < 200; i++) begin
         tick();
         if (ratio_busy && ph == 0) begin
            ph = 1;
            if (!(ratio_req == RW'(LOW_R) && vid_req == o_v && pkg_state == S_ENTER))
               vals_ok = 1'b0;
         end
         if (vid_busy) begin
            if (ph == 0) order_ok = 1'b0;
            if (ph == 1) begin
               ph = 2;
               if (!(ratio_req == RW'(LOW_R) && vid_req == VW'(LOW_V))) vals_ok = 1'b0;
            end
         end
         if (pkg_state == S_XHALT) break;
      end
      chk(order_ok && ph == 2, "R4 ratio step before VID step", ph, 2);
      chk(vals_ok, "R4 request values during entry", int'(vals_ok), 1);
      chk(pkg_state == S_XHALT && ratio_req == RW'(LOW_R) && vid_req == VW'(LOW_V),
          "R4 deep halt reached at low point", int'(pkg_state), int'(S_XHALT));
   endtask

   task automatic leave_ext(input logic [RW-1:0] o_r, input logic [VW-1:0] o_v);
      int ph = 0;
      bit order_ok = 1'b1;
      bit vals_ok  = 1'b1;
      wake_evt  = 1'b1;
      core_halt = '0;
      for (int i = 0; i < 200; i++) begin
         tick();
         wake_evt = 1'b0;
         if (vid_busy && ph == 0) begin
            ph = 1;
            if (!(vid_req == o_v && ratio_req == RW'(LOW_R))) vals_ok = 1'b0;
         end
         if (ratio_busy) begin
            if (ph == 0) order_ok = 1'b0;
            if (ph == 1) begin
               ph = 2;
               if (!(ratio_req == o_r && vid_req == o_v)) vals_ok = 1'b0;
            end
         end
         if (pkg_state == S_RUN) break;
      end
      chk(order_ok && ph == 2, "R5 VID step before ratio step", ph, 2);
      chk(vals_ok, "R6 restored values equal captured values", int'(vals_ok), 1);
      chk(pkg_state == S_RUN, "R5 back in run", int'(pkg_state), int'(S_RUN));
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      summary();
      $finish;
   end

   initial begin
      bit hit;
      bit ok;
      logic [RW-1:0] o_r;
      logic [VW-1:0] o_v;
      void'($urandom(32'd4242));
      core_halt = '0; xhalt_en = 1'b0; wake_evt = 1'b0; stop_clk_req = 1'b0;
      snoop_req = 1'b0; ratio_ack = 1'b0; vid_ack = 1'b0;
      run_ratio = RW'(40); run_vid = VW'(90);
      do_reset();

      // R1 reset state
      chk(pkg_state == S_RUN, "R1 state after reset", int'(pkg_state), 0);
      chk(!ratio_busy && !vid_busy, "R1 busy after reset", int'({ratio_busy, vid_busy}), 0);
      chk(seq_err == 1'b0, "R1 error after reset", int'(seq_err), 0);
      chk(ratio_req == run_ratio && vid_req == run_vid, "R1 requests follow run inputs",
          int'(ratio_req), int'(run_ratio));

      snoop_chk("R9 snoop in run");

      // R8 stop clock from run
      stop_clk_req = 1'b1;
      wait_ind(S_STOP, 5, hit);
      chk(hit, "R8 stop entered from run", int'(pkg_state), int'(S_STOP));
      stop_clk_req = 1'b0;
      wait_ind(S_RUN, 5, hit);
      chk(hit, "R8 back to run after release", int'(pkg_state), int'(S_RUN));

      // R2 random partial halt masks
      for (int it = 0; it < 30; it++) begin
         logic [N-1:0] m;
         m = N'($urandom);
         m[$urandom_range(0, N-1)] = 1'b0;
         xhalt_en  = 1'($urandom);
         core_halt = m;
         ok = 1'b1;
         repeat (8) begin
            tick();
            if (expect_run(m) && (pkg_state != S_RUN || ratio_busy || vid_busy)) ok = 1'b0;
         end
         chk(ok, "R2 partial halt stays in run", int'(pkg_state), int'(S_RUN));
      end
      core_halt = '0;
      repeat (4) tick();

      // R3 plain halt
      xhalt_en  = 1'b0;
      core_halt = all_mask();
      wait_ind(S_HALT, 10, hit);
      chk(hit, "R3 plain halt entered", int'(pkg_state), int'(S_HALT));
      chk(!ratio_busy && !vid_busy && ratio_req == run_ratio && vid_req == run_vid,
          "R3 no ratio or VID change", int'(ratio_req), int'(run_ratio));
      snoop_chk("R9 snoop in plain halt");

      // R7 stop clock in plain halt
      stop_clk_req = 1'b1;
      wait_ind(S_STOP, 5, hit);
      chk(hit, "R7 stop entered from halt", int'(pkg_state), int'(S_STOP));
      repeat (4) tick();
      stop_clk_req = 1'b0;
      wait_ind(S_HALT, 5, hit);
      chk(hit, "R7 release returns to halt", int'(pkg_state), int'(S_HALT));
      repeat (3) tick();
      chk(pkg_state == S_HALT, "R7 remains in halt", int'(pkg_state), int'(S_HALT));

      core_halt = '0;
      wait_ind(S_RUN, 10, hit);
      chk(hit, "R3 un-halt returns to run", int'(pkg_state), int'(S_RUN));

      // R4..R7 deep halt round trips with random operating points
      for (int it = 0; it < 5; it++) begin
         run_ratio = RW'($urandom_range(LOW_R + 1, (1 << RW) - 1));
         run_vid   = VW'($urandom_range(LOW_V + 1, (1 << VW) - 1));
         o_r = run_ratio;
         o_v = run_vid;
         enter_ext(o_r, o_v);
         if (it == 0) snoop_chk("R9 snoop in deep halt");
         run_ratio = RW'($urandom_range(LOW_R + 1, (1 << RW) - 1));
         run_vid   = VW'($urandom_range(LOW_V + 1, (1 << VW) - 1));
         stop_clk_req = 1'b1;
         wait_ind(S_STOP, 5, hit);
         chk(hit && ratio_req == RW'(LOW_R) && vid_req == VW'(LOW_V),
             "R7 stop in deep halt keeps low point", int'(vid_req), LOW_V);
         stop_clk_req = 1'b0;
         wait_ind(S_XHALT, 5, hit);
         chk(hit, "R7 release returns to deep halt", int'(pkg_state), int'(S_XHALT));
         leave_ext(o_r, o_v);
         tick();
         chk(ratio_req == run_ratio && vid_req == run_vid, "R6 requests follow inputs in run",
             int'(vid_req), int'(run_vid));
         repeat (4) tick();
      end

      // R10 acknowledge timeout
      auto_ack = 1'b0;
      o_r = run_ratio;
      o_v = run_vid;
      xhalt_en  = 1'b1;
      core_halt = all_mask();
      hit = 1'b0;
      for (int i = 0; i < 20; i++) begin
         tick();
         if (ratio_busy) begin
            hit = 1'b1;
            break;
         end
      end
      chk(hit, "R10 ratio step pending", int'(ratio_busy), 1);
      repeat (TMO - 2) tick();
      chk(seq_err == 1'b0, "R10 no error before timeout", int'(seq_err), 0);
      repeat (4) tick();
      chk(seq_err == 1'b1, "R10 error after timeout", int'(seq_err), 1);
      auto_ack = 1'b1;
      wait_ind(S_XHALT, 50, hit);
      chk(hit, "R10 sequence completes after late ack", int'(pkg_state), int'(S_XHALT));
      leave_ext(o_r, o_v);
      chk(seq_err == 1'b1, "R10 error stays set", int'(seq_err), 1);
      do_reset();
      chk(seq_err == 1'b0 && pkg_state == S_RUN, "R1 reset clears error", int'(seq_err), 0);

      chk(bad11 == 0, "R11 busy flags exclusive", bad11, 0);

      summary();
      $finish;
   end

endmodule